// File: doc/BRIEF.md
# Four-Step Value Chain Checker

This block watches an 8-bit result bus and confirms that, once an enable precondition is seen, the bus walks through a fixed chain of four values on four consecutive rising clock edges. The first value of the chain is a parameter (`START_VAL`, default 0). The next three values are the constants 6, 9 and 3, in that order.

A new attempt may begin on every edge at which enable is high, so attempts can overlap. Every attempt that has started is followed edge by edge until it either breaks the chain or completes it. The block drives registered pass and fail pulses, and keeps two saturating event counters.

Each later step is held in a slot. A slot has two named states, `SLOT_IDLE` and `SLOT_ARMED`. Slot k (k = 1..3) takes the ARM transition to `SLOT_ARMED` when the step before it matched at the previous edge. It takes the DROP transition back to `SLOT_IDLE` in every other case. Step 0 is not held in a slot: it is the enable input itself. The output process registers the pulses from the hit and miss results of all four steps.

Top module: `seq_chain_checker`

## Requirements
- R1: An active-low reset, whether applied at start or in the middle of a run, drives both pulses and both counters to 0 and sets every slot to idle. Attempts in flight before the reset produce no pass or fail after it.
- R2: An edge with `en_i` low starts no attempt. When no attempt is in flight, such an edge causes no pulse and no counter change.
- R3: An attempt passes when `result_i` equals `START_VAL` at its start edge, then 6, then 9, then 3 on the three following edges. `pass_o` is high for the one cycle after the edge that samples the 3.
- R4: When an attempt in flight sees a value other than the one its current step expects, that attempt ends. `fail_o` is high for the one cycle after that edge. The same happens when enable is high and the start value is wrong. A failed attempt never produces a later pass.
- R5: Attempts that start on consecutive edges are tracked independently. A pass of one attempt and a failure of another can occur at the same edge.
- R6: When several attempts fail at the same edge, one `fail_o` pulse is produced, and `fail_cnt_o` grows by the number of attempts that failed.
- R7: `pass_cnt_o` grows by one for each completed attempt. Both counters update at the same edge as the pulse they record.
- R8: Both counters are 16 bits wide and stop at 65535 instead of wrapping.
- R9: `START_VAL` sets the expected first value. It defaults to 0 and can be overridden, for example to 4.
- R10: Enable is looked at only on the start edge. The later steps are checked whatever `en_i` holds on those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Precondition; when high, an attempt starts on this edge |
| result_i | input | 8 | Bus being checked |
| fail_o | output | 1 | One-cycle pulse after an edge at which any attempt broke the chain |
| pass_o | output | 1 | One-cycle pulse after an edge at which an attempt completed |
| fail_cnt_o | output | 16 | Saturating count of failed attempts |
| pass_cnt_o | output | 16 | Saturating count of completed attempts |

## Verification
The bench runs the chain values with enable low, to confirm they trigger nothing. A design that treated enable as a level to be held would raise spurious failures there. It breaks the chain at the middle steps, where a design that forgot a slot would pass broken chains, and it holds enable high so that one attempt passes while a newly started one fails at the same edge. Two failures at a single edge check that the counter adds both, where a one-bit increment would undercount. A long run of failures pushes the counter to its ceiling, where a wrapping design would fall back to zero. A reset in mid-attempt checks that an armed slot does not survive it.

// File: rtl/seq_chain_pkg.sv
package seq_chain_pkg;

    localparam int NUM_STEPS = 4;

    typedef enum logic {
        SLOT_IDLE  = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_e;

    // Value expected at a given step of the chain.
    function automatic int step_value(input int idx, input int first);
        case (idx)
            0:       step_value = first;
            1:       step_value = 6;
            2:       step_value = 9;
            default: step_value = 3;
        endcase
    endfunction

endpackage

// File: rtl/seq_step_match.sv
module seq_step_match #(
    parameter int DATA_W  = 8,
    parameter int EXP_VAL = 0
) (
    input  logic              active_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              hit_o,
    output logic              miss_o
);
    localparam logic [DATA_W-1:0] EXP_L = EXP_VAL[DATA_W-1:0];

    logic equal;

    always_comb begin
        equal  = (value_i == EXP_L);
        hit_o  = active_i && equal;
        miss_o = active_i && !equal;
    end

endmodule

// File: rtl/seq_sat_counter.sv
module seq_sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (sum[CNT_W]) begin
            cnt_q <= CNT_MAX;
        end else begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;

    // R8: once at the ceiling, the count stays there.
    assert_count_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cnt_q) == CNT_MAX) |-> (cnt_q == CNT_MAX));

    // R7: a count never goes down between resets.
    assert_count_monotonic_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q >= $past(cnt_q));

endmodule

// File: rtl/seq_chain_checker.sv
module seq_chain_checker
    import seq_chain_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int START_VAL = 0,
    parameter int CNT_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              fail_o,
    output logic              pass_o,
    output logic [CNT_W-1:0]  fail_cnt_o,
    output logic [CNT_W-1:0]  pass_cnt_o
);
    localparam int LAST  = NUM_STEPS - 1;
    localparam int INC_W = $clog2(NUM_STEPS + 1);

    slot_e slot_q [1:LAST];
    slot_e slot_d [1:LAST];

    logic [NUM_STEPS-1:0] active;
    logic [NUM_STEPS-1:0] hit;
    logic [NUM_STEPS-1:0] miss;
    logic [INC_W-1:0]     fail_inc;
    logic                 any_live;

    // Step 0 is the enable input itself; later steps come from armed slots.
    assign active[0] = en_i;

    for (genvar s = 1; s < NUM_STEPS; s++) begin : g_active
        assign active[s] = (slot_q[s] == SLOT_ARMED);
    end

    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
        seq_step_match #(
            .DATA_W  (DATA_W),
            .EXP_VAL (step_value(k, START_VAL))
        ) u_match (
            .active_i (active[k]),
            .value_i  (result_i),
            .hit_o    (hit[k]),
            .miss_o   (miss[k])
        );
    end

    assign any_live = |active[LAST:1];

    // Next state: ARM when the step before matched, otherwise DROP to idle.
    always_comb begin
        for (int s = 1; s <= LAST; s++) begin
            unique case (hit[s-1])
                1'b1:    slot_d[s] = SLOT_ARMED;
                default: slot_d[s] = SLOT_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 1; s <= LAST; s++) slot_q[s] <= SLOT_IDLE;
        end else begin
            for (int s = 1; s <= LAST; s++) slot_q[s] <= slot_d[s];
        end
    end

    // Output register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fail_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            fail_o <= |miss;
            pass_o <= hit[LAST];
        end
    end

    always_comb begin
        fail_inc = '0;
        for (int k = 0; k < NUM_STEPS; k++) fail_inc = fail_inc + INC_W'(miss[k]);
    end

    seq_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_fail_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (fail_inc),
        .cnt_o  (fail_cnt_o)
    );

    seq_sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_pass_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (hit[LAST]),
        .cnt_o  (pass_cnt_o)
    );

    // R2: the first slot is armed only if enable was seen on the edge before.
    assert_start_needs_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_q[1] == SLOT_ARMED) |-> $past(en_i));

    // R2: with no enable and nothing in flight, no pulse follows.
    assert_quiet_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(en_i) && !$past(any_live)) |-> (!fail_o && !pass_o));

    // R3: a pass requires the final slot to have been armed on the edge before.
    assert_pass_after_final_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_o |-> $past(slot_q[LAST] == SLOT_ARMED));

    // R6: each fail pulse comes with a counter change unless it is saturated.
    assert_fail_counted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> ((fail_cnt_o != $past(fail_cnt_o)) || (fail_cnt_o == {CNT_W{1'b1}})));

    // R7: each pass pulse comes with a counter change unless it is saturated.
    assert_pass_counted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_o |-> ((pass_cnt_o != $past(pass_cnt_o)) || (pass_cnt_o == {CNT_W{1'b1}})));

endmodule

// File: tb/test_seq_chain_checker.sv
module test_seq_chain_checker;

    localparam int TB_S0 = 4;   // R9: override of the start value
    localparam int MAXC  = 65535;

    typedef struct {
        logic        fail;
        logic        pass;
        logic [15:0] fcnt;
        logic [15:0] pcnt;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  res = 8'h00;
    logic        fail_o, pass_o;
    logic [15:0] fail_cnt_o, pass_cnt_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    exp_t q[$];
    int   att[$];
    int   m_fc = 0;
    int   m_pc = 0;

    always #4 clk = ~clk;   // 125 MHz

    seq_chain_checker #(.START_VAL(TB_S0)) i_seq_chain_checker (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .result_i   (res),
        .fail_o     (fail_o),
        .pass_o     (pass_o),
        .fail_cnt_o (fail_cnt_o),
        .pass_cnt_o (pass_cnt_o)
    );

    function automatic int expv(input int k);
        case (k)
            0:       expv = TB_S0;
            1:       expv = 6;
            2:       expv = 9;
            default: expv = 3;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Driver: applies one edge of stimulus and pushes the expected outcome.
    task automatic drive(input bit e, input logic [7:0] v, input string tag);
        int nxt[$];
        int nf = 0;
        int np = 0;
        exp_t it;
        @(negedge clk);
        en  = e;
        res = v;
        foreach (att[i]) begin
            if (int'(v) == expv(att[i])) begin
                if (att[i] == 3) np++;
                else nxt.push_back(att[i] + 1);
            end else begin
                nf++;
            end
        end
        if (e) begin
            if (int'(v) == expv(0)) nxt.push_back(1);
            else nf++;
        end
        att  = nxt;
        m_fc = (m_fc + nf > MAXC) ? MAXC : m_fc + nf;
        m_pc = (m_pc + np > MAXC) ? MAXC : m_pc + np;
        it.fail = (nf > 0);
        it.pass = (np > 0);
        it.fcnt = 16'(m_fc);
        it.pcnt = 16'(m_pc);
        it.tag  = tag;
        q.push_back(it);
    endtask

    // Monitor: compares registered outputs after the edge that produced them.
    always @(posedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check({it.tag, " fail pulse R4"}, int'(fail_o), int'(it.fail));
            check({it.tag, " pass pulse R3"}, int'(pass_o), int'(it.pass));
            check({it.tag, " fail count R6"}, int'(fail_cnt_o), int'(it.fcnt));
            check({it.tag, " pass count R7"}, int'(pass_cnt_o), int'(it.pcnt));
        end
    end

    task automatic apply_reset();
        wait (q.size() == 0);
        @(negedge clk);
        rst_n = 1'b0;
        en = 1'b0;
        att.delete();
        m_fc = 0;
        m_pc = 0;
        repeat (2) @(negedge clk);
        check("R1 reset fail_o", int'(fail_o), 0);
        check("R1 reset pass_o", int'(pass_o), 0);
        check("R1 reset fail_cnt", int'(fail_cnt_o), 0);
        check("R1 reset pass_cnt", int'(pass_cnt_o), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        apply_reset();

        // R2: chain values with enable low trigger nothing.
        drive(0, 8'd4, "R2"); drive(0, 8'd6, "R2");
        drive(0, 8'd9, "R2"); drive(0, 8'd3, "R2");

        // R3, R9, R10: full chain, enable only on the start edge.
        drive(1, 8'd4, "R3"); drive(0, 8'd6, "R10");
        drive(0, 8'd9, "R10"); drive(0, 8'd3, "R3");
        drive(0, 8'd0, "R2");

        // R4: break at the third step; no later pass.
        drive(1, 8'd4, "R4"); drive(0, 8'd6, "R4");
        drive(0, 8'd7, "R4"); drive(0, 8'd3, "R4");

        // R4: wrong start value with enable high.
        drive(1, 8'd5, "R4"); drive(0, 8'd0, "R4");

        // R5: enable held high; pass and fail at the same edge.
        drive(1, 8'd4, "R5"); drive(1, 8'd6, "R5");
        drive(1, 8'd9, "R5"); drive(1, 8'd3, "R5");
        drive(0, 8'd0, "R5");

        // R6: two attempts fail at one edge.
        drive(1, 8'd4, "R6"); drive(1, 8'd4, "R6");
        drive(1, 8'd4, "R6"); drive(1, 8'd0, "R6");
        drive(0, 8'd0, "R6");

        // R1: reset in mid-attempt clears the armed slots.
        drive(1, 8'd4, "R1"); drive(0, 8'd6, "R1");
        apply_reset();
        drive(0, 8'd9, "R1"); drive(0, 8'd3, "R1");
        drive(0, 8'd0, "R1");

        // R7: a second completed attempt after reset.
        drive(1, 8'd4, "R7"); drive(1, 8'd6, "R7");
        drive(0, 8'd9, "R7"); drive(0, 8'd3, "R7");

        // R8: drive the fail counter to its ceiling and beyond.
        for (int i = 0; i < 65540; i++) drive(1, 8'hFF, "R8");
        wait (q.size() == 0);
        @(negedge clk);
        check("R8 fail count saturated", int'(fail_cnt_o), MAXC);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule